// File: doc/BRIEF.md
# Clear-on-Read Status Flag Bank

This block keeps a small bank of status registers that collect single-cycle condition pulses from the rest of a motor-driver core. Each register holds seven sticky flags and is presented to the serial host interface as one byte. The top bit of that byte is a parity bit computed over the seven flags. An active-low error pin is asserted while any flag marked as an error is held anywhere in the bank.

The serial host interface drives the chip-select line `csb_i`, which is active low, and sends one read strobe per register. While a transfer is in progress (`csb_i` low) the bank is frozen, so the bytes being shifted out cannot change. Events that arrive during the transfer are parked and are merged in at the first clock with `csb_i` high. A read marks its register for clearing. The clear is applied at that same first high clock, and an event that lands on the clearing edge still sets its flag.

Top module: `stat_bank_top`

## Requirements
- R1: After reset every status byte reads 0x00 and `err_no` is 1.
- R2: Bit 7 of each status byte is 1 when bits 6:0 hold an odd number of ones, and 0 when that count is even. Status byte r is `stat_o[8r+7:8r]`, and flag b of register r is driven by `evt_i[7r+b]`.
- R3: A pulse on `evt_i[7r+b]` in a cycle with `csb_i` high sets flag b of register r at that clock edge. The flag then stays set until register r is cleared.
- R4: While `csb_i` is low the status bytes do not change, whatever arrives on `evt_i` and `rd_stb_i`.
- R5: Events that arrive while `csb_i` is low appear in the status bytes at the first clock edge with `csb_i` high.
- R6: A pulse on `rd_stb_i[r]` during a transfer clears register r at the first clock edge with `csb_i` high. The other registers are unaffected.
- R7: An event for register r on the edge at which register r is cleared leaves that flag set.
- R8: `err_no` is 0 exactly when some set flag has its bit in `ERR_MASK` (bit 7r+b) set. With the default mask only flags 3:0 of each register are errors, so flags 6:4 never pull `err_no` low.
- R9: `err_no` changes only at clock edges with `csb_i` high, and it follows the flags that are latched on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_REGS*FLAG_W | Condition pulses, one per flag |
| csb_i | input | 1 | Serial chip select, low during a transfer |
| rd_stb_i | input | NUM_REGS | Read strobe per status register |
| stat_o | output | NUM_REGS*(FLAG_W+1) | Status bytes, each with the parity bit on top |
| err_no | output | 1 | Error pin, active low |

## Verification
The bench builds the bank with its defaults: four registers of seven flags, and an error mask covering flags 3:0 of each register. This keeps the error and non-error flags apart, so the bench can show that flags 6:4 set without lowering the pin. It also reaches a full register whose seven ones give an odd parity. With four registers the bench can clear one register while its neighbours keep their flags, and it can clear every register in one transfer while an event lands on the clearing edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned FLAG_W_DEF = 7;
  localparam int unsigned NUM_REGS_DEF = 4;

  function automatic logic odd_ones(input logic [FLAG_W_DEF-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/stat_slice.sv
module stat_slice #(
  parameter int unsigned FLAG_W = 7,
  parameter logic [FLAG_W-1:0] ERR_BITS = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              rd_i,
  output logic [FLAG_W:0]   byte_o,
  output logic              err_nxt_o
);
  logic [FLAG_W-1:0] flags_q, pend_q, flags_d;
  logic              clr_q;

  // set wins over clear: OR in after masking
  assign flags_d   = (clr_q ? '0 : flags_q) | evt_i | pend_q;
  assign err_nxt_o = |(flags_d & ERR_BITS);
  assign byte_o    = {^flags_q, flags_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pend_q  <= '0;
      clr_q   <= 1'b0;
    end else if (upd_i) begin
      flags_q <= flags_d;
      pend_q  <= '0;
      clr_q   <= rd_i;
    end else begin
      pend_q  <= pend_q | evt_i;
      clr_q   <= clr_q | rd_i;
    end
  end

  AST_FROZEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_q)); // R4
  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R7
  AST_PEND_MERGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ((flags_q & $past(pend_q)) == $past(pend_q))); // R5
  AST_CLEAR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && clr_q && evt_i == '0 && pend_q == '0) |=> (flags_q == '0)); // R6
endmodule

// File: rtl/stat_err_out.sv
module stat_err_out #(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic [NUM_REGS-1:0] err_nxt_i,
  output logic                err_no
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (upd_i) err_q <= |err_nxt_i;
  end

  assign err_no = ~err_q;

  AST_PIN_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(err_no)); // R9
endmodule

// File: rtl/stat_bank_top.sv
module stat_bank_top #(
  parameter int unsigned NUM_REGS = stat_pkg::NUM_REGS_DEF,
  parameter int unsigned FLAG_W   = stat_pkg::FLAG_W_DEF,
  parameter logic [NUM_REGS*FLAG_W-1:0] ERR_MASK = {NUM_REGS{7'b000_1111}}
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REGS*FLAG_W-1:0]   evt_i,
  input  logic                         csb_i,
  input  logic [NUM_REGS-1:0]          rd_stb_i,
  output logic [NUM_REGS*(FLAG_W+1)-1:0] stat_o,
  output logic                         err_no
);
  localparam int unsigned BYTE_W = FLAG_W + 1;

  logic [NUM_REGS-1:0]        err_nxt;
  logic [NUM_REGS*FLAG_W-1:0] flag_vec;
  logic                       upd;

  assign upd = csb_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    stat_slice #(
      .FLAG_W  (FLAG_W),
      .ERR_BITS(ERR_MASK[r*FLAG_W +: FLAG_W])
    ) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (upd),
      .evt_i    (evt_i[r*FLAG_W +: FLAG_W]),
      .rd_i     (rd_stb_i[r]),
      .byte_o   (stat_o[r*BYTE_W +: BYTE_W]),
      .err_nxt_o(err_nxt[r])
    );
    assign flag_vec[r*FLAG_W +: FLAG_W] = stat_o[r*BYTE_W +: FLAG_W];
  end

  stat_err_out #(.NUM_REGS(NUM_REGS)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .err_nxt_i(err_nxt),
    .err_no   (err_no)
  );

  AST_PIN_MATCHES_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_no == !(|(flag_vec & ERR_MASK))); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (flag_vec == '0)); // R1
endmodule

// File: tb/tb_stat_bank_top.sv
module tb_stat_bank_top;
  localparam int NR = 4;
  localparam int FW = 7;
  localparam logic [NR*FW-1:0] MASK = {NR{7'b000_1111}};

  logic clk_i = 1'b0, rst_ni = 1'b0, csb_i = 1'b1;
  logic [NR*FW-1:0] evt_i = '0;
  logic [NR-1:0]    rd_stb_i = '0;
  logic [NR*8-1:0]  stat_o;
  logic             err_no;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference state
  logic [FW-1:0] m_flag [NR];
  logic [FW-1:0] m_pend [NR];
  logic          m_clr  [NR];
  logic          m_err;

  logic [NR*8-1:0] q_stat [$];
  logic            q_err  [$];
  string           q_tag  [$];

  stat_bank_top dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [NR*8-1:0] exp_bytes();
    logic [NR*8-1:0] v;
    for (int r = 0; r < NR; r++) begin
      int ones = 0;
      for (int b = 0; b < FW; b++) ones += m_flag[r][b];
      v[r*8 +: 8] = {(ones % 2 == 1), m_flag[r]};
    end
    return v;
  endfunction

  task automatic push(string tag);
    q_stat.push_back(exp_bytes());
    q_err.push_back(!m_err);
    q_tag.push_back(tag);
  endtask

  // driver: apply inputs, advance model, push expectation after the edge
  task automatic step(logic csb, logic [NR*FW-1:0] evt, logic [NR-1:0] rd, string tag);
    csb_i = csb; evt_i = evt; rd_stb_i = rd;
    for (int r = 0; r < NR; r++) begin
      if (csb) begin
        m_flag[r] = (m_clr[r] ? '0 : m_flag[r]) | evt[r*FW +: FW] | m_pend[r];
        m_pend[r] = '0;
        m_clr[r]  = rd[r];
      end else begin
        m_pend[r] = m_pend[r] | evt[r*FW +: FW];
        m_clr[r]  = m_clr[r] | rd[r];
      end
    end
    if (csb) begin
      m_err = 1'b0;
      for (int r = 0; r < NR; r++) m_err |= |(m_flag[r] & MASK[r*FW +: FW]);
    end
    @(posedge clk_i);
    push(tag);
    #2;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q_stat.size() > 0) begin
      logic [NR*8-1:0] es;
      logic ee;
      string t;
      es = q_stat.pop_front(); ee = q_err.pop_front(); t = q_tag.pop_front();
      checks++;
      if (stat_o !== es || err_no !== ee) begin
        failures++;
        $display("FAIL %s: stat=%h err_n=%b expected stat=%h err_n=%b", t, stat_o, err_no, es, ee);
      end
    end
  end

  function automatic logic [NR*FW-1:0] ev(int r, logic [FW-1:0] bits);
    logic [NR*FW-1:0] v = '0;
    v[r*FW +: FW] = bits;
    return v;
  endfunction

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_flag[r] = '0; m_pend[r] = '0; m_clr[r] = 1'b0;
    end
    m_err = 1'b0;
    repeat (2) @(posedge clk_i);
    push("R1 reset");
    #2 rst_ni = 1'b1;
    step(1, '0, '0, "R1 idle after reset");
    step(1, ev(0, 7'h01), '0, "R3 R2 R8 set error flag, odd parity");
    step(1, '0, '0, "R3 flag sticky");
    step(1, ev(1, 7'h03), '0, "R2 even parity");
    step(0, ev(2, 7'h04), 4'b0001, "R4 frozen during transfer");
    step(0, '0, '0, "R4 R9 still frozen");
    step(1, '0, '0, "R5 R6 pending merged, reg0 cleared");
    step(1, '0, '0, "R6 neighbours kept");
    step(0, '0, 4'b1111, "R4 read all");
    step(1, ev(3, 7'h20), '0, "R7 R8 set on clear edge, non-error flag");
    step(0, ev(1, 7'h08), '0, "R9 pin held during transfer");
    step(0, '0, '0, "R9 pin still held");
    step(1, '0, '0, "R5 R9 pin follows merged error");
    step(0, '0, 4'b0010, "R9 read reg1");
    step(1, '0, '0, "R6 R8 error cleared pin released");
    step(1, ev(0, 7'h7F), '0, "R2 seven ones");
    step(1, ev(2, 7'h70), '0, "R8 non-error flags only in reg2");
    step(0, ev(3, 7'h01), 4'b0101, "R4 mixed transfer");
    step(1, ev(0, 7'h02), '0, "R7 R5 R6 clear with event and pending");
    step(1, '0, '0, "R3 final state");
    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule